// File: doc/BRIEF.md
# Stream Identifier Span Filter Matcher

This block decides, one transaction at a time, whether an incoming stream identifier passes the filter in front of a performance counter. Two programmed values steer it: a match pattern as wide as the identifier, and a one-bit span select. With span off, the identifier must equal the pattern in every bit. With span on, the pattern carries its own don't-care width. A run of trailing ones, ended by the first zero, marks the low bits that are ignored. All bits above that zero must equal the identifier. No separate mask register exists.

Software writes the pattern through a pattern slot of a small write port. It writes the span select through a slot that takes a whole event-type word, of which only bit 29 is kept. A transaction is offered with a valid strobe. The verdict comes back one clock later as a result-valid strobe and a match flag. After reset the filter is open, so every identifier is counted until software programs something narrower.

Top module: `sid_span_matcher`

## Requirements
- R1: After reset, res_valid_o and match_o are low. The pattern is all ones and span is on, so any valid identifier matches.
- R2: res_valid_o is high in the cycle after a cycle with in_valid high, and low otherwise. match_o is never high without res_valid_o.
- R3: With span off, match_o is high exactly when in_sid equals the pattern in all bits.
- R4: With span on, let t be the number of consecutive ones in the pattern counted up from bit 0. Bits 0 to t are ignored, and bits t+1 and above must equal in_sid for a match.
- R5: With span on and an all-ones pattern, every identifier matches.
- R6: With span on and pattern 0x42, identifiers 0x42 and 0x43 match, and 0x40, 0x41 and 0x44 do not.
- R7: A write with cfg_sel = 0 loads cfg_wdata[ID_W-1:0] as the pattern. A write with cfg_sel = 1 loads span from cfg_wdata[29], and every other bit of that word is ignored.
- R8: A write takes effect for transactions in later cycles. A transaction offered in the same cycle as a write is judged with the old pattern and span.
- R9: With span on and an all-zeros pattern, only bit 0 is ignored, so identifiers 0 and 1 match and no other identifier does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 selects the pattern, 1 selects the event-type word |
| cfg_wdata | input | CFG_W | Write data |
| in_valid | input | 1 | Transaction strobe |
| in_sid | input | ID_W | Transaction stream identifier |
| res_valid_o | output | 1 | Verdict valid, one cycle after in_valid |
| match_o | output | 1 | Identifier passed the filter |

## Verification
On an 8-bit build, the bench sweeps every pattern against every identifier in span mode. This covers the all-ones pattern, where a carry-based mask that wrapped wrongly would reject identifiers, and the all-zeros pattern, where a mask one bit too wide or too narrow would add or drop identifier 1. Exact mode is swept over a spread of patterns, so that a design which kept some mask in exact mode would show false hits. The bench also writes type words with bit 29 cleared and junk in the other bits, which catches a span taken from the wrong bit. A transaction offered in the same cycle as a write catches a design that forwards the new value too early.

// File: rtl/sid_filt_pkg.sv
package sid_filt_pkg;
  // width of a configuration write word
  localparam int unsigned CFG_W = 32;
  // span select position inside the event-type word
  localparam int unsigned SPAN_BIT = 29;

  typedef enum logic {
    SEL_PATTERN = 1'b0,
    SEL_TYPE    = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/sid_cfg_regs.sv
module sid_cfg_regs
  import sid_filt_pkg::*;
#(
  parameter int unsigned ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [ID_W-1:0] pat_q,
  output logic            span_q
);
  // named write events, also used by the assertions
  logic pat_wr;
  logic type_wr;

  assign pat_wr  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_PATTERN);
  assign type_wr = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_TYPE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= '1;
      span_q <= 1'b1;
    end else begin
      if (pat_wr)  pat_q  <= cfg_wdata[ID_W-1:0];
      if (type_wr) span_q <= cfg_wdata[SPAN_BIT];
    end
  end

  // R7
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_wr |=> $stable(pat_q));
  // R7
  span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !type_wr |=> $stable(span_q));
endmodule

// File: rtl/sid_mask_gen.sv
module sid_mask_gen #(
  parameter int unsigned ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] pat,
  output logic [ID_W-1:0] ign_mask
);
  // ones over the trailing-ones run and the first zero above it
  function automatic logic [ID_W-1:0] trail_mask(input logic [ID_W-1:0] p);
    logic [ID_W-1:0] nxt;
    nxt = p + ID_W'(1);
    return p ^ nxt;
  endfunction

  logic [ID_W-1:0] mask_inc;

  assign ign_mask = trail_mask(pat);
  assign mask_inc = ign_mask + ID_W'(1);

  // R4
  mask_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ign_mask[0]);
  // R4
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_inc));
  // R5
  mask_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&pat) |-> (&ign_mask));
endmodule

// File: rtl/sid_compare.sv
module sid_compare #(
  parameter int unsigned ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [ID_W-1:0] in_sid,
  input  logic [ID_W-1:0] pat,
  input  logic [ID_W-1:0] ign_mask,
  input  logic            span,
  output logic            res_valid_q,
  output logic            match_q
);
  logic [ID_W-1:0] bit_miss;
  logic            hit_now;

  for (genvar gi = 0; gi < ID_W; gi++) begin : g_bit
    assign bit_miss[gi] = (in_sid[gi] ^ pat[gi]) & ~(span & ign_mask[gi]);
  end

  assign hit_now = ~|bit_miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      match_q     <= 1'b0;
    end else begin
      res_valid_q <= in_valid;
      match_q     <= in_valid && hit_now;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid_q);
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid_q);
  // R2
  match_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> res_valid_q);
  // R3
  exact_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !span && (in_sid == pat)) |=> match_q);
  // R3
  exact_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !span && (in_sid != pat)) |=> !match_q);
  // R5
  open_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && span && (&pat)) |=> match_q);
endmodule

// File: rtl/sid_span_matcher.sv
module sid_span_matcher
  import sid_filt_pkg::*;
#(
  parameter int unsigned ID_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             in_valid,
  input  logic [ID_W-1:0]  in_sid,
  output logic             res_valid_o,
  output logic             match_o
);
  logic [ID_W-1:0] pat_q;
  logic            span_q;
  logic [ID_W-1:0] ign_mask;

  sid_cfg_regs #(.ID_W(ID_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pat_q(pat_q), .span_q(span_q)
  );

  sid_mask_gen #(.ID_W(ID_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .pat(pat_q), .ign_mask(ign_mask)
  );

  sid_compare #(.ID_W(ID_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sid(in_sid),
    .pat(pat_q), .ign_mask(ign_mask), .span(span_q),
    .res_valid_q(res_valid_o), .match_q(match_o)
  );
endmodule

// File: tb/sid_span_matcher_tb_top.sv
`timescale 1ns/1ps
module sid_span_matcher_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_sid = '0;
  logic res_valid_o, match_o;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] m_pat = '1;
  logic m_span = 1'b1;
  logic p_v = 1'b0, p_exp = 1'b0;
  string p_tag = "";

  always #10 clk = ~clk;

  sid_span_matcher #(.ID_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sid(in_sid),
    .res_valid_o(res_valid_o), .match_o(match_o)
  );

  // reference: walk the bits, count the trailing ones, compare the rest
  function automatic logic ref_hit(logic [W-1:0] p, logic [W-1:0] id, logic sp);
    int t;
    if (!sp) return id == p;
    t = 0;
    while (t < W && p[t]) t++;
    for (int i = 0; i < W; i++)
      if (i > t && id[i] != p[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one cycle: check the previous verdict, then drive the next inputs
  task automatic step(logic v, logic [W-1:0] id, logic we, logic sel,
                      logic [31:0] wd, string tag);
    @(negedge clk);
    check(res_valid_o, p_v, {p_tag, " (R2 valid)"});
    check(match_o, p_v & p_exp, p_tag);
    p_v = v;
    p_exp = v ? ref_hit(m_pat, id, m_span) : 1'b0;
    p_tag = tag;
    in_valid = v; in_sid = id;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    if (we) begin
      if (!sel) m_pat = wd[W-1:0];
      else m_span = wd[29];
    end
  endtask

  task automatic wr(logic sel, logic [31:0] wd);
    step(1'b0, '0, 1'b1, sel, wd, "R7 write");
  endtask

  task automatic tx(logic [W-1:0] id, string tag);
    step(1'b1, id, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(res_valid_o, 1'b0, "R1 reset valid");
    check(match_o, 1'b0, "R1 reset match");
    rst_n = 1'b1;
    // default filter open
    tx(8'h5A, "R1 default open");
    tx(8'h00, "R1 default open");
    step(1'b0, 8'hFF, 1'b0, 1'b0, '0, "R2 idle");
    // worked example
    wr(1'b0, 32'h0000_0042);
    tx(8'h42, "R6 0x42"); tx(8'h43, "R6 0x43");
    tx(8'h40, "R6 0x40"); tx(8'h41, "R6 0x41"); tx(8'h44, "R6 0x44");
    // span off through junk-filled type word (R7)
    wr(1'b1, 32'hDFFF_FFFF);
    tx(8'h43, "R7 span cleared"); tx(8'h42, "R7 span cleared");
    wr(1'b1, 32'h2000_0000);
    tx(8'h43, "R7 span set");
    // R8: same-cycle write uses old values
    wr(1'b0, 32'h0000_0010);
    step(1'b1, 8'h10, 1'b1, 1'b0, 32'h0000_0020, "R8 old pattern");
    tx(8'h10, "R8 new pattern"); tx(8'h20, "R8 new pattern");
    step(1'b1, 8'h21, 1'b1, 1'b1, 32'h0, "R8 old span");
    tx(8'h21, "R8 new span off");
    wr(1'b1, 32'h2000_0000);
    // exhaustive span sweep (R4, R5, R9)
    for (int p = 0; p < 256; p++) begin
      wr(1'b0, 32'(p));
      for (int id = 0; id < 256; id++)
        tx(W'(id), p == 255 ? "R5 all-ones" : (p == 0 ? "R9 all-zeros" : "R4 span"));
    end
    // exact sweep (R3)
    wr(1'b1, 32'h0);
    for (int k = 0; k < 34; k++) begin
      wr(1'b0, 32'((k * 37 + k / 33 * 255) & 8'hFF));
      for (int id = 0; id < 256; id++) tx(W'(id), "R3 exact");
    end
    step(1'b0, '0, 1'b0, 1'b0, '0, "R2 flush");
    step(1'b0, '0, 1'b0, 1'b0, '0, "R2 flush");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule